// File: doc/BRIEF.md
# Privileged System Instruction Gate

This block rules on three privileged system instructions: supervisor return, wait-for-interrupt and the virtual-memory fence. For each instruction presented to it, it decides whether the instruction may run. It bases that decision on the current privilege level, on whether the hart implements supervisor mode, and on three trap-control bits taken from the machine status register. The unit's response is one of four outcomes. It raises an illegal-instruction exception, requests a return sequence, requests a wait, or requests a translation-cache flush.

A flush request carries two qualifiers: an address and an address-space identifier. A zero source-register index means "every address" or "every identifier". In that case the register value is not passed on.

The execute stage presents one decoded instruction per cycle with `req_valid`. The gate captures it and drives a registered one-cycle response on the following cycle. The control state machine has two states:
- `ST_IDLE` means no response is pending.
- `ST_RESP` means a response is on the outputs this cycle.

Its transitions are:
- `ST_IDLE`→`ST_RESP` when a request arrives.
- `ST_RESP`→`ST_RESP` on a back-to-back request.
- `ST_RESP`→`ST_IDLE` when the request line is low.
- Both states go back to `ST_IDLE` on reset.

The return sequence, the wait mechanism and the translation cache are handled elsewhere.

Top module: `sysop_gate`

## Requirements
- R1: While `rst_n` is low, every output is 0. This holds even if `req_valid` is high.
- R2: A request sampled with `req_valid`=1 on a rising edge gives `resp_valid`=1 for exactly the next cycle, with exactly one of `resp_illegal`, `resp_return`, `resp_wait` or `resp_flush` set. Without a request, `resp_valid` and all four outcome flags are 0.
- R3: Supervisor return (`req_op`=00):
  - In user mode (`req_priv`=00) it is always illegal.
  - In supervisor mode (01) it is illegal when `sup_present`=0 or `trap_sup_ret`=1, and otherwise it requests a return.
  - In machine mode (11) it is illegal when `sup_present`=0, and otherwise it requests a return.
- R4: Wait-for-interrupt (`req_op`=01):
  - In machine mode it always requests a wait.
  - In supervisor mode it is illegal when `trap_wait`=1, and otherwise it requests a wait.
  - In user mode it is illegal.
- R5: Virtual-memory fence (`req_op`=10):
  - In user mode it is illegal.
  - In supervisor mode it is illegal when `trap_vm`=1, and otherwise it requests a flush.
  - In machine mode it always requests a flush.
- R6: On a flush response, `flush_all_addr`=1 and `flush_addr`=0 when `rs1_idx` was 0; otherwise `flush_all_addr`=0 and `flush_addr` is the captured `rs1_val`. The pair `flush_all_asid`/`flush_asid` follows the same rule using `rs2_idx` and `rs2_val`.
- R7: Privilege encoding 10 is reserved, and any request carrying it is illegal. Operation code 11 is reserved and is illegal at every privilege level.
- R8: On any response other than a flush, and in idle cycles, `flush_all_addr`, `flush_all_asid`, `flush_addr` and `flush_asid` are 0.
- R9: Back-to-back requests on consecutive cycles each receive their own response on consecutive cycles. No request is dropped and no field leaks from one request into another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A decoded instruction is presented this cycle |
| req_op | input | 2 | 00 supervisor return, 01 wait-for-interrupt, 10 fence, 11 reserved |
| req_priv | input | 2 | 00 user, 01 supervisor, 10 reserved, 11 machine |
| sup_present | input | 1 | Supervisor mode is implemented |
| trap_sup_ret | input | 1 | Trap supervisor return taken in supervisor mode |
| trap_wait | input | 1 | Trap wait-for-interrupt taken in supervisor mode |
| trap_vm | input | 1 | Trap fence taken in supervisor mode |
| rs1_idx | input | IDX_W | Fence address register index |
| rs2_idx | input | IDX_W | Fence address-space register index |
| rs1_val | input | XLEN | Fence address register value |
| rs2_val | input | XLEN | Fence address-space register value |
| resp_valid | output | 1 | Response pulse |
| resp_illegal | output | 1 | Raise illegal-instruction exception |
| resp_return | output | 1 | Request supervisor return sequence |
| resp_wait | output | 1 | Request wait for interrupt |
| resp_flush | output | 1 | Request translation-cache flush |
| flush_all_addr | output | 1 | Flush applies to every address |
| flush_all_asid | output | 1 | Flush applies to every address space |
| flush_addr | output | XLEN | Flush address qualifier |
| flush_asid | output | XLEN | Flush address-space qualifier |

## Verification
Two things can share a single clock edge: the response for one instruction and the capture of the next. A verdict from request N can therefore be on the outputs while the qualifiers or trap bits of request N+1 are being sampled.

The bench provokes this by sweeping every combination of operation, privilege, supervisor-present flag and trap bit with no gap between requests. The sweep is then repeated with idle cycles inserted. Its model predicts each response from the inputs held at the edge where that request was captured. Every cycle it compares the outcome flags and qualifiers against that prediction, so any mixing of adjacent requests shows up as a mismatch.

// File: rtl/sysop_pkg.sv
package sysop_pkg;

    typedef enum logic [1:0] {
        PRIV_USER    = 2'b00,
        PRIV_SUPER   = 2'b01,
        PRIV_RSVD    = 2'b10,
        PRIV_MACHINE = 2'b11
    } priv_t;

    typedef enum logic [1:0] {
        OP_SUP_RETURN = 2'b00,
        OP_WAIT_IRQ   = 2'b01,
        OP_VM_FENCE   = 2'b10,
        OP_RSVD       = 2'b11
    } sysop_t;

    typedef enum logic [1:0] {
        VERD_ILLEGAL = 2'd0,
        VERD_RETURN  = 2'd1,
        VERD_WAIT    = 2'd2,
        VERD_FLUSH   = 2'd3
    } verdict_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } gate_state_t;

    localparam int unsigned NUM_QUAL = 2;

endpackage

// File: rtl/sysop_legal.sv
module sysop_legal
    import sysop_pkg::*;
(
    input  sysop_t   op,
    input  priv_t    priv,
    input  logic     sup_present,
    input  logic     trap_sup_ret,
    input  logic     trap_wait,
    input  logic     trap_vm,
    output verdict_t verdict
);

    verdict_t ret_v;
    verdict_t wait_v;
    verdict_t fence_v;

    // Supervisor return decision
    always_comb begin
        unique case (priv)
            PRIV_SUPER:   ret_v = (sup_present && !trap_sup_ret) ? VERD_RETURN : VERD_ILLEGAL;
            PRIV_MACHINE: ret_v = sup_present ? VERD_RETURN : VERD_ILLEGAL;
            default:      ret_v = VERD_ILLEGAL;
        endcase
    end

    // Wait-for-interrupt decision
    always_comb begin
        unique case (priv)
            PRIV_SUPER:   wait_v = trap_wait ? VERD_ILLEGAL : VERD_WAIT;
            PRIV_MACHINE: wait_v = VERD_WAIT;
            default:      wait_v = VERD_ILLEGAL;
        endcase
    end

    // Virtual-memory fence decision
    always_comb begin
        unique case (priv)
            PRIV_SUPER:   fence_v = trap_vm ? VERD_ILLEGAL : VERD_FLUSH;
            PRIV_MACHINE: fence_v = VERD_FLUSH;
            default:      fence_v = VERD_ILLEGAL;
        endcase
    end

    always_comb begin
        unique case (op)
            OP_SUP_RETURN: verdict = ret_v;
            OP_WAIT_IRQ:   verdict = wait_v;
            OP_VM_FENCE:   verdict = fence_v;
            default:       verdict = VERD_ILLEGAL;
        endcase
    end

endmodule

// File: rtl/sysop_qual.sv
module sysop_qual #(
    parameter int unsigned XLEN  = 32,
    parameter int unsigned IDX_W = 5
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [XLEN-1:0]  val,
    output logic             is_all,
    output logic [XLEN-1:0]  qual
);

    localparam logic [IDX_W-1:0] ZERO_IDX = '0;

    always_comb begin
        is_all = (idx == ZERO_IDX);
        qual   = is_all ? '0 : val;
    end

endmodule

// File: rtl/sysop_gate.sv
module sysop_gate
    import sysop_pkg::*;
#(
    parameter int unsigned XLEN  = 32,
    parameter int unsigned IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_op,
    input  logic [1:0]       req_priv,
    input  logic             sup_present,
    input  logic             trap_sup_ret,
    input  logic             trap_wait,
    input  logic             trap_vm,
    input  logic [IDX_W-1:0] rs1_idx,
    input  logic [IDX_W-1:0] rs2_idx,
    input  logic [XLEN-1:0]  rs1_val,
    input  logic [XLEN-1:0]  rs2_val,
    output logic             resp_valid,
    output logic             resp_illegal,
    output logic             resp_return,
    output logic             resp_wait,
    output logic             resp_flush,
    output logic             flush_all_addr,
    output logic             flush_all_asid,
    output logic [XLEN-1:0]  flush_addr,
    output logic [XLEN-1:0]  flush_asid
);

    verdict_t    verdict;
    gate_state_t state_q;
    gate_state_t state_d;

    logic [IDX_W-1:0] idx_arr [NUM_QUAL];
    logic [XLEN-1:0]  val_arr [NUM_QUAL];
    logic             all_arr [NUM_QUAL];
    logic [XLEN-1:0]  qual_arr[NUM_QUAL];

    assign idx_arr[0] = rs1_idx;
    assign idx_arr[1] = rs2_idx;
    assign val_arr[0] = rs1_val;
    assign val_arr[1] = rs2_val;

    sysop_legal u_legal (
        .op           (sysop_t'(req_op)),
        .priv         (priv_t'(req_priv)),
        .sup_present  (sup_present),
        .trap_sup_ret (trap_sup_ret),
        .trap_wait    (trap_wait),
        .trap_vm      (trap_vm),
        .verdict      (verdict)
    );

    for (genvar g = 0; g < NUM_QUAL; g++) begin : g_qual
        sysop_qual #(.XLEN(XLEN), .IDX_W(IDX_W)) u_qual (
            .idx    (idx_arr[g]),
            .val    (val_arr[g]),
            .is_all (all_arr[g]),
            .qual   (qual_arr[g])
        );
    end

    // Next-state selection
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = req_valid ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = req_valid ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign resp_valid = (state_q == ST_RESP);

    // Registered outcome and qualifiers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_illegal   <= 1'b0;
            resp_return    <= 1'b0;
            resp_wait      <= 1'b0;
            resp_flush     <= 1'b0;
            flush_all_addr <= 1'b0;
            flush_all_asid <= 1'b0;
            flush_addr     <= '0;
            flush_asid     <= '0;
        end else begin
            resp_illegal <= req_valid && (verdict == VERD_ILLEGAL);
            resp_return  <= req_valid && (verdict == VERD_RETURN);
            resp_wait    <= req_valid && (verdict == VERD_WAIT);
            resp_flush   <= req_valid && (verdict == VERD_FLUSH);
            if (req_valid && (verdict == VERD_FLUSH)) begin
                flush_all_addr <= all_arr[0];
                flush_all_asid <= all_arr[1];
                flush_addr     <= qual_arr[0];
                flush_asid     <= qual_arr[1];
            end else begin
                flush_all_addr <= 1'b0;
                flush_all_asid <= 1'b0;
                flush_addr     <= '0;
                flush_asid     <= '0;
            end
        end
    end

endmodule

// File: rtl/sysop_gate_chk.sv
module sysop_gate_chk #(
    parameter int unsigned XLEN  = 32,
    parameter int unsigned IDX_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [1:0]       req_op,
    input logic [1:0]       req_priv,
    input logic             sup_present,
    input logic             trap_sup_ret,
    input logic             trap_wait,
    input logic             trap_vm,
    input logic [IDX_W-1:0] rs1_idx,
    input logic [IDX_W-1:0] rs2_idx,
    input logic [XLEN-1:0]  rs1_val,
    input logic [XLEN-1:0]  rs2_val,
    input logic             resp_valid,
    input logic             resp_illegal,
    input logic             resp_return,
    input logic             resp_wait,
    input logic             resp_flush,
    input logic             flush_all_addr,
    input logic             flush_all_asid,
    input logic [XLEN-1:0]  flush_addr,
    input logic [XLEN-1:0]  flush_asid
);

    logic [3:0] flags;
    assign flags = {resp_illegal, resp_return, resp_wait, resp_flush};

    always_comb begin
        if (!rst_n) begin
            AST_RESET_QUIET: assert (!resp_valid && flags == 4'b0 && !flush_all_addr) else $error("reset outputs"); // R1
        end
    end

    AST_PULSE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_valid); // R2
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!resp_valid && flags == 4'b0)); // R2
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> $countones(flags) == 1); // R2
    AST_USER_RET_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'b00 && req_priv == 2'b00) |=> resp_illegal); // R3
    AST_MACHINE_WAIT_OK: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'b01 && req_priv == 2'b11) |=> resp_wait); // R4
    AST_SUPER_FENCE_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'b10 && req_priv == 2'b01 && trap_vm) |=> resp_illegal); // R5
    AST_ALL_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'b10 && req_priv == 2'b11 && rs1_idx == '0) |=> (flush_all_addr && flush_addr == '0)); // R6
    AST_ADDR_PASSED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'b10 && req_priv == 2'b11 && rs1_idx != '0) |=> (!flush_all_addr && flush_addr == $past(rs1_val))); // R6
    AST_RSVD_PRIV: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_priv == 2'b10) |=> resp_illegal); // R7
    AST_QUAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !resp_flush |-> (!flush_all_addr && !flush_all_asid && flush_addr == '0 && flush_asid == '0)); // R8

endmodule

bind sysop_gate sysop_gate_chk #(.XLEN(XLEN), .IDX_W(IDX_W)) chk_i (.*);

// File: tb/sysop_gate_tb_top.sv
`timescale 1ns/1ps
module sysop_gate_tb_top;

    localparam int XLEN  = 32;
    localparam int IDX_W = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic [1:0]       req_op = '0;
    logic [1:0]       req_priv = '0;
    logic             sup_present = 1'b0;
    logic             trap_sup_ret = 1'b0;
    logic             trap_wait = 1'b0;
    logic             trap_vm = 1'b0;
    logic [IDX_W-1:0] rs1_idx = '0;
    logic [IDX_W-1:0] rs2_idx = '0;
    logic [XLEN-1:0]  rs1_val = '0;
    logic [XLEN-1:0]  rs2_val = '0;
    logic             resp_valid, resp_illegal, resp_return, resp_wait, resp_flush;
    logic             flush_all_addr, flush_all_asid;
    logic [XLEN-1:0]  flush_addr, flush_asid;

    int checks = 0;
    int fails  = 0;
    bit prev_exp_valid = 1'b0;

    always #2 clk = ~clk;

    sysop_gate #(.XLEN(XLEN), .IDX_W(IDX_W)) dut_i (.*);

    // Outcome codes of the model: 0 illegal, 1 return, 2 wait, 3 flush
    function automatic int model_kind(input logic [1:0] op, input logic [1:0] pv,
                                      input logic sp, input logic tr, input logic tw, input logic tv);
        if (pv == 2'b10 || op == 2'b11) return 0;        // R7
        if (op == 2'b00) begin                            // R3
            if (pv == 2'b00) return 0;
            if (pv == 2'b01) return (sp && !tr) ? 1 : 0;
            return sp ? 1 : 0;
        end
        if (op == 2'b01) begin                            // R4
            if (pv == 2'b11) return 2;
            if (pv == 2'b01) return tw ? 0 : 2;
            return 0;
        end
        if (pv == 2'b00) return 0;                        // R5
        if (pv == 2'b01) return tv ? 0 : 3;
        return 3;
    endfunction

    task automatic chk(input string tag, input logic [79:0] act, input logic [79:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Predict from the inputs in place, step one edge, compare.
    task automatic cycle();
        logic        e_valid;
        int          k;
        logic [3:0]  e_flags;
        logic [65:0] e_qual;
        string       op_tag;
        e_valid = req_valid;
        k = model_kind(req_op, req_priv, sup_present, trap_sup_ret, trap_wait, trap_vm);
        e_flags = '0;
        e_qual  = '0;
        if (e_valid) begin
            e_flags = 4'b1000 >> k;
            if (k == 3) begin
                e_qual[65] = (rs1_idx == 0);
                e_qual[64] = (rs2_idx == 0);
                e_qual[63:32] = (rs1_idx == 0) ? 32'h0 : rs1_val;
                e_qual[31:0]  = (rs2_idx == 0) ? 32'h0 : rs2_val;
            end
        end
        if (req_priv == 2'b10 || req_op == 2'b11) op_tag = "R7";
        else if (req_op == 2'b00) op_tag = "R3";
        else if (req_op == 2'b01) op_tag = "R4";
        else op_tag = "R5";
        @(posedge clk);
        #1;
        chk((prev_exp_valid && e_valid) ? "R9 pulse" : "R2 pulse", {79'b0, resp_valid}, {79'b0, e_valid});
        if (e_valid) chk({op_tag, " outcome"}, {76'b0, resp_illegal, resp_return, resp_wait, resp_flush}, {76'b0, e_flags});
        else         chk("R2 idle outcome", {76'b0, resp_illegal, resp_return, resp_wait, resp_flush}, 80'b0);
        chk((e_valid && k == 3) ? "R6 qualifiers" : "R8 qualifiers",
            {14'b0, flush_all_addr, flush_all_asid, flush_addr, flush_asid}, {14'b0, e_qual});
        prev_exp_valid = e_valid;
    endtask

    task automatic put(input logic v, input logic [1:0] op, input logic [1:0] pv, input logic sp,
                       input logic [2:0] tb, input logic [4:0] i1, input logic [4:0] i2,
                       input logic [31:0] v1, input logic [31:0] v2);
        req_valid = v; req_op = op; req_priv = pv; sup_present = sp;
        trap_sup_ret = tb[2]; trap_wait = tb[1]; trap_vm = tb[0];
        rs1_idx = i1; rs2_idx = i2; rs1_val = v1; rs2_val = v2;
        cycle();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        $display("FAIL R2 watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks + 1);
        $finish;
    end

    initial begin : stim
        int n;
        // R1: reset holds outputs low even with a request presented
        req_valid = 1'b1; req_op = 2'b10; req_priv = 2'b11;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset", {14'b0, resp_valid, resp_illegal, resp_return, resp_wait, resp_flush,
                         flush_all_addr, flush_all_asid, flush_addr[28:0], flush_asid[29:0]}, 80'b0);
        req_valid = 1'b0;
        @(posedge clk); #1;
        rst_n = 1'b1;
        cycle();

        // Exhaustive sweep, back-to-back (R9), then with idle gaps
        for (int pass = 0; pass < 2; pass++) begin
            n = 0;
            for (int op = 0; op < 4; op++)
                for (int pv = 0; pv < 4; pv++)
                    for (int sp = 0; sp < 2; sp++)
                        for (int t = 0; t < 8; t++) begin
                            put(1'b1, op[1:0], pv[1:0], sp[0], t[2:0], 5'((n * 7) % 4), 5'((n * 3) % 5),
                                32'hA5A50000 + n, 32'h00C30000 ^ (n * 17));
                            if (pass == 1 && (n % 3) == 2) put(1'b0, 2'b10, 2'b11, 1'b1, 3'b000, 5'd4, 5'd4, 32'hFFFF, 32'hEEEE);
                            n++;
                        end
        end

        // R6: qualifier index patterns in machine mode, plus supervisor with trap clear
        put(1'b1, 2'b10, 2'b11, 1'b0, 3'b111, 5'd0,  5'd0,  32'h1234_5678, 32'h9ABC_DEF0);
        put(1'b1, 2'b10, 2'b11, 1'b0, 3'b111, 5'd0,  5'd9,  32'h1234_5678, 32'h0000_0042);
        put(1'b1, 2'b10, 2'b11, 1'b1, 3'b000, 5'd31, 5'd0,  32'hDEAD_BEEF, 32'h5555_5555);
        put(1'b1, 2'b10, 2'b01, 1'b1, 3'b110, 5'd1,  5'd2,  32'hFFFF_FFFF, 32'h0000_0001);
        // R8: an illegal fence after a flush carries no qualifiers
        put(1'b1, 2'b10, 2'b01, 1'b1, 3'b001, 5'd1,  5'd2,  32'hFFFF_FFFF, 32'h0000_0001);
        put(1'b0, 2'b00, 2'b00, 1'b0, 3'b000, 5'd0,  5'd0,  32'h0, 32'h0);
        put(1'b0, 2'b00, 2'b00, 1'b0, 3'b000, 5'd0,  5'd0,  32'h0, 32'h0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule